// File: doc/BRIEF.md
# Word-Level Permission Check Cache

This block sits beside a processor's load, store and fetch path and decides, for every access, whether the protection domain that is currently active may touch the addressed 64-bit word. Permissions are held per word inside one shared address space, so separate software modules can be fenced off from each other without separate address spaces. A small fully associative cache keeps permission rows. Each row covers an aligned block of words and is tagged by domain identifier and block address. When a lookup misses, the block asks an external table walker for the row, using the table root pointer held in an internal register, and stalls the requester until the row comes back.

The same lookup also checks transfers between domains. A transfer request names a target word and a target domain. It succeeds only when that word carries a gate mark. A successful transfer makes the target domain current. A change of domain, or a write of a new table root, empties the cache, so a row fetched for one domain or table is never reused for another.

Top module: `wperm_guard`

## Requirements
- R1: After reset, req_ready is 1, resp_valid, fault and fill_req are 0, pd_cur equals RESET_PD (0), and every cache entry is invalid, so the first access misses.
- R2: Each word's permission is a 2-bit code: 00 none, 01 read-only, 10 read-write, 11 execute-read. A load (req_kind 00) is allowed for any code other than 00.
- R3: A store (req_kind 01) is allowed only for code 10. A fetch (req_kind 10) is allowed only for code 11.
- R4: An accepted request that hits gives resp_valid with its verdict in the next cycle and raises no fill request.
- R5: On a miss, fill_req rises in the next cycle, with fill_blk = req_addr >> 4, fill_pd = pd_cur and fill_root = the current root pointer. It stays high until fill_ack. The verdict appears on resp_valid in the cycle after fill_ack. In fill_data, bits [2w+1:2w] hold the code of word w and bit 32+w holds the gate mark of word w.
- R6: From the acceptance of a miss until its response, req_ready is 0 and req_valid is ignored. Each miss causes exactly one fill.
- R7: fault is high for exactly the response cycle of a denied access and low otherwise.
- R8: A domain transfer (req_kind 11) is allowed exactly when the target word's gate bit is 1, whatever its code. When it is allowed, pd_cur takes req_target_pd in the response cycle. When it is denied, pd_cur keeps its value.
- R9: A change of pd_cur, or a root write (root_we) while no fill is outstanding, invalidates all entries. A root write while a fill is outstanding is ignored. A lookup accepted in the same cycle as a root write is judged on the entries as they stood before that write.
- R10: Fills replace entries in round-robin order. The pointer advances by one on every fill and is not reset by invalidation. With 8 entries, the ninth distinct block evicts the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 domain transfer |
| req_addr | input | 32 | Word address |
| req_target_pd | input | 8 | Domain entered by a transfer |
| resp_valid | output | 1 | Verdict valid |
| resp_allow | output | 1 | Access allowed |
| fault | output | 1 | Pulse on a denied access |
| pd_cur | output | 8 | Current protection domain |
| root_we | input | 1 | Write the table root pointer |
| root_in | input | 32 | New root pointer |
| fill_req | output | 1 | Row fetch outstanding |
| fill_root | output | 32 | Table root for the fetch |
| fill_pd | output | 8 | Domain of the fetch |
| fill_blk | output | 28 | Block address of the fetch |
| fill_ack | input | 1 | Row returned |
| fill_data | input | 48 | Per-word codes and gate marks |

## Verification
Two events can meet in one clock edge: a root pointer write and the acceptance of a lookup. This is provoked both on purpose and at random, by driving root_we together with req_valid on a block that is cached or on one that is not. The verdict must come from the old row when the lookup hits, and the following access to that block must miss and fetch with the new root. A root write that arrives while a fetch is outstanding is also driven, together with a stray request. Later fetches must still carry the old root, and only one fetch may have been issued for that miss.

// File: rtl/wperm_pkg.sv
package wperm_pkg;

  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_FETCH = 2'd2,
    K_GATE  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] PERM_NONE = 2'd0;
  localparam logic [1:0] PERM_RO   = 2'd1;
  localparam logic [1:0] PERM_RW   = 2'd2;
  localparam logic [1:0] PERM_XR   = 2'd3;

  // Verdict for one access given the word's code and gate mark.
  function automatic logic grant_ok(input acc_kind_e k, input logic [1:0] p, input logic g);
    case (k)
      K_LOAD:  return p != PERM_NONE;
      K_STORE: return p == PERM_RW;
      K_FETCH: return p == PERM_XR;
      default: return g;
    endcase
  endfunction

endpackage

// File: rtl/wperm_store.sv
module wperm_store #(
  parameter int ENTRIES = 8,
  parameter int PD_W    = 8,
  parameter int TAG_W   = 28,
  parameter int DATA_W  = 48,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PD_W-1:0]    look_pd,
  input  logic [TAG_W-1:0]   look_tag,
  output logic               hit,
  output logic [DATA_W-1:0]  hit_data,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PD_W-1:0]    wr_pd,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               flush,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [PD_W-1:0]    e_pd  [ENTRIES];
  logic [TAG_W-1:0]   e_tag [ENTRIES];
  logic [DATA_W-1:0]  e_dat [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_vec <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_pd[i]  <= '0;
        e_tag[i] <= '0;
        e_dat[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush) begin
          valid_vec[i] <= 1'b0;
        end else if (wr_en && wr_idx == IDX_W'(i)) begin
          valid_vec[i] <= 1'b1;
        end
        if (wr_en && wr_idx == IDX_W'(i)) begin
          e_pd[i]  <= wr_pd;
          e_tag[i] <= wr_tag;
          e_dat[i] <= wr_data;
        end
      end
    end
  end

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign match[i] = valid_vec[i] && (e_pd[i] == look_pd) && (e_tag[i] == look_tag);
    end
  endgenerate

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_data = hit_data | e_dat[i];
    end
  end

  assign hit = |match;

endmodule

// File: rtl/wperm_victim.sv
module wperm_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (adv) begin
      idx <= (idx == IDX_W'(ENTRIES - 1)) ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/wperm_guard.sv
module wperm_guard
  import wperm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PD_W      = 8,
  parameter int PTR_W     = 32,
  parameter int BLK_WORDS = 16,
  parameter int ENTRIES   = 8,
  parameter int RESET_PD  = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [1:0]                          req_kind,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [PD_W-1:0]                     req_target_pd,
  output logic                                resp_valid,
  output logic                                resp_allow,
  output logic                                fault,
  output logic [PD_W-1:0]                     pd_cur,
  input  logic                                root_we,
  input  logic [PTR_W-1:0]                    root_in,
  output logic                                fill_req,
  output logic [PTR_W-1:0]                    fill_root,
  output logic [PD_W-1:0]                     fill_pd,
  output logic [ADDR_W-$clog2(BLK_WORDS)-1:0] fill_blk,
  input  logic                                fill_ack,
  input  logic [3*BLK_WORDS-1:0]              fill_data
);

  localparam int OFF_W = $clog2(BLK_WORDS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int ROW_W = 3 * BLK_WORDS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [1:0] word_code(input logic [ROW_W-1:0] row, input logic [OFF_W-1:0] o);
    return row[2*int'(o) +: 2];
  endfunction

  function automatic logic word_gate(input logic [ROW_W-1:0] row, input logic [OFF_W-1:0] o);
    return row[2*BLK_WORDS + int'(o)];
  endfunction

  // Pending miss and architectural state
  logic              busy_q;
  acc_kind_e         pk_kind;
  logic [ADDR_W-1:0] pk_addr;
  logic [PD_W-1:0]   pk_tpd;
  logic [PTR_W-1:0]  root_q;
  logic [PD_W-1:0]   pd_q;

  // Response registers, also watched by the checker
  acc_kind_e         resp_kind;
  logic [1:0]        resp_perm;
  logic              resp_gate;

  // Named internal events
  logic              accept;
  logic              lk_hit;
  logic [ROW_W-1:0]  lk_row;
  logic              fill_take;
  logic              dec_valid;
  acc_kind_e         dec_kind;
  logic [OFF_W-1:0]  dec_off;
  logic [ROW_W-1:0]  dec_row;
  logic [1:0]        dec_perm;
  logic              dec_gate;
  logic [PD_W-1:0]   dec_tpd;
  logic              dec_allow;
  logic              pd_switch;
  logic              root_take;
  logic              flush_evt;
  logic [IDX_W-1:0]  victim;
  logic [ENTRIES-1:0] valid_vec;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign fill_take = busy_q && fill_ack;
  assign root_take = root_we && !busy_q;

  wperm_store #(
    .ENTRIES (ENTRIES),
    .PD_W    (PD_W),
    .TAG_W   (TAG_W),
    .DATA_W  (ROW_W),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_pd   (pd_q),
    .look_tag  (req_addr[ADDR_W-1:OFF_W]),
    .hit       (lk_hit),
    .hit_data  (lk_row),
    .wr_en     (fill_take),
    .wr_idx    (victim),
    .wr_pd     (pd_q),
    .wr_tag    (pk_addr[ADDR_W-1:OFF_W]),
    .wr_data   (fill_data),
    .flush     (flush_evt),
    .valid_vec (valid_vec)
  );

  wperm_victim #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fill_take),
    .idx   (victim)
  );

  // Decision path: either a hit on a fresh request or the returning fill
  always_comb begin
    dec_valid = (accept && lk_hit) || fill_take;
    if (busy_q) begin
      dec_kind = pk_kind;
      dec_off  = pk_addr[OFF_W-1:0];
      dec_row  = fill_data;
      dec_tpd  = pk_tpd;
    end else begin
      dec_kind = acc_kind_e'(req_kind);
      dec_off  = req_addr[OFF_W-1:0];
      dec_row  = lk_row;
      dec_tpd  = req_target_pd;
    end
    dec_perm  = word_code(dec_row, dec_off);
    dec_gate  = word_gate(dec_row, dec_off);
    dec_allow = grant_ok(dec_kind, dec_perm, dec_gate);
    pd_switch = dec_valid && dec_allow && (dec_kind == K_GATE) && (dec_tpd != pd_q);
    flush_evt = root_take || pd_switch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pk_kind    <= K_LOAD;
      pk_addr    <= '0;
      pk_tpd     <= '0;
      root_q     <= '0;
      pd_q       <= PD_W'(RESET_PD);
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      fault      <= 1'b0;
      resp_kind  <= K_LOAD;
      resp_perm  <= PERM_NONE;
      resp_gate  <= 1'b0;
    end else begin
      resp_valid <= dec_valid;
      fault      <= dec_valid && !dec_allow;
      if (dec_valid) begin
        resp_allow <= dec_allow;
        resp_kind  <= dec_kind;
        resp_perm  <= dec_perm;
        resp_gate  <= dec_gate;
      end
      if (accept && !lk_hit) begin
        busy_q  <= 1'b1;
        pk_kind <= acc_kind_e'(req_kind);
        pk_addr <= req_addr;
        pk_tpd  <= req_target_pd;
      end else if (fill_take) begin
        busy_q <= 1'b0;
      end
      if (root_take) root_q <= root_in;
      if (pd_switch) pd_q <= dec_tpd;
    end
  end

  assign pd_cur    = pd_q;
  assign fill_req  = busy_q;
  assign fill_root = root_q;
  assign fill_pd   = pd_q;
  assign fill_blk  = pk_addr[ADDR_W-1:OFF_W];

endmodule

// File: rtl/wperm_chk.sv
module wperm_chk
  import wperm_pkg::*;
#(
  parameter int PD_W    = 8,
  parameter int BLK_W   = 28,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               fill_req,
  input logic               fill_ack,
  input logic [BLK_W-1:0]   fill_blk,
  input logic               accept,
  input logic               lk_hit,
  input logic               resp_valid,
  input logic               resp_allow,
  input logic               fault,
  input acc_kind_e          resp_kind,
  input logic [1:0]         resp_perm,
  input logic               resp_gate,
  input logic [PD_W-1:0]    pd_cur,
  input logic               flush_evt,
  input logic [ENTRIES-1:0] valid_vec
);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_ack |=> fill_req && $stable(fill_blk));

  p_hit_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && lk_hit |=> resp_valid && !fill_req);

  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (resp_valid && !resp_allow));

  p_store_rw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_allow && resp_kind == K_STORE |-> resp_perm == PERM_RW);

  p_fetch_xr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_allow && resp_kind == K_FETCH |-> resp_perm == PERM_XR);

  p_load_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_kind == K_LOAD |-> resp_allow == (resp_perm != PERM_NONE));

  p_gate_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_kind == K_GATE |-> resp_allow == resp_gate);

  p_pd_only_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_cur) |-> resp_valid && resp_allow && resp_kind == K_GATE);

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> valid_vec == '0);

endmodule

bind wperm_guard wperm_chk #(
  .PD_W    (PD_W),
  .BLK_W   (ADDR_W - $clog2(BLK_WORDS)),
  .ENTRIES (ENTRIES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .fill_req   (fill_req),
  .fill_ack   (fill_ack),
  .fill_blk   (fill_blk),
  .accept     (accept),
  .lk_hit     (lk_hit),
  .resp_valid (resp_valid),
  .resp_allow (resp_allow),
  .fault      (fault),
  .resp_kind  (resp_kind),
  .resp_perm  (resp_perm),
  .resp_gate  (resp_gate),
  .pd_cur     (pd_cur),
  .flush_evt  (flush_evt),
  .valid_vec  (valid_vec)
);

// File: tb/sim_wperm_guard.sv
`timescale 1ns/1ps
module sim_wperm_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic [7:0]  req_target_pd;
  logic        resp_valid;
  logic        resp_allow;
  logic        fault;
  logic [7:0]  pd_cur;
  logic        root_we;
  logic [31:0] root_in;
  logic        fill_req;
  logic [31:0] fill_root;
  logic [7:0]  fill_pd;
  logic [27:0] fill_blk;
  logic        fill_ack;
  logic [47:0] fill_data;

  always #2 clk = ~clk;

  wperm_guard u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_target_pd(req_target_pd),
    .resp_valid(resp_valid), .resp_allow(resp_allow), .fault(fault), .pd_cur(pd_cur),
    .root_we(root_we), .root_in(root_in),
    .fill_req(fill_req), .fill_root(fill_root), .fill_pd(fill_pd), .fill_blk(fill_blk),
    .fill_ack(fill_ack), .fill_data(fill_data)
  );

  int checks = 0;
  int errors = 0;
  int fills  = 0;
  bit done   = 0;

  // Reference model state
  bit          mv   [8];
  logic [27:0] mtag [8];
  int          mrr  = 0;
  logic [7:0]  cur_pd   = 8'd0;
  logic [31:0] cur_root = 32'd0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Table contents: {gate, code} for a word, any mixing that spreads the codes
  function automatic logic [2:0] tbl(input logic [7:0] pd, input logic [31:0] root, input logic [31:0] wa);
    logic [31:0] h;
    h = (wa ^ ({24'd0, pd} << 7) ^ root) * 32'h9E3779B1;
    h = h ^ (h >> 13);
    return h[2:0];
  endfunction

  function automatic bit want(input logic [1:0] k, input logic [1:0] code, input bit g);
    if (k == 2'd0) return code != 2'd0;
    if (k == 2'd1) return code == 2'd2;
    if (k == 2'd2) return code == 2'd3;
    return g;
  endfunction

  function automatic string tag_of(input logic [1:0] k);
    if (k == 2'd0) return "R2";
    if (k == 2'd3) return "R8";
    return "R3";
  endfunction

  function automatic bit m_look(input logic [27:0] t);
    for (int i = 0; i < 8; i++) if (mv[i] && mtag[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_flush();
    for (int i = 0; i < 8; i++) mv[i] = 1'b0;
  endtask

  task automatic m_insert(input logic [27:0] t);
    mv[mrr] = 1'b1;
    mtag[mrr] = t;
    mrr = (mrr + 1) % 8;
  endtask

  // Table walker stand-in
  initial begin
    int dly;
    fill_ack = 1'b0;
    fill_data = '0;
    dly = 0;
    forever begin
      @(negedge clk);
      if (fill_ack) begin
        fill_ack = 1'b0;
      end else if (fill_req) begin
        if (dly == 0) begin
          for (int w = 0; w < 16; w++) begin
            logic [2:0] e;
            e = tbl(fill_pd, fill_root, {fill_blk, 4'(w)});
            fill_data[2*w +: 2] = e[1:0];
            fill_data[32 + w]   = e[2];
          end
          fill_ack = 1'b1;
          fills++;
          dly = $urandom % 3;
        end else begin
          dly--;
        end
      end
    end
  end

  task automatic write_root(input logic [31:0] v);
    @(negedge clk);
    root_we = 1'b1;
    root_in = v;
    @(negedge clk);
    root_we = 1'b0;
    cur_root = v;
    m_flush();
  endtask

  task automatic access(input logic [1:0] k, input logic [31:0] a, input logic [7:0] tpd,
                        input bit poke, input bit root_same, input logic [31:0] new_root);
    logic [27:0] t;
    logic [31:0] old_root;
    logic [2:0]  e;
    bit          hit;
    bit          ea;
    int          f0;
    int          n;
    t = a[31:4];
    @(negedge clk);
    chk(req_ready == 1'b1, "R6", req_ready, 1);
    hit = m_look(t);
    old_root = cur_root;
    if (root_same) begin
      cur_root = new_root;
      m_flush();
    end
    e = hit ? tbl(cur_pd, old_root, a) : tbl(cur_pd, cur_root, a);
    ea = want(k, e[1:0], e[2]);
    req_valid = 1'b1;
    req_kind = k;
    req_addr = a;
    req_target_pd = tpd;
    root_we = root_same;
    root_in = new_root;
    f0 = fills;
    @(negedge clk);
    req_valid = 1'b0;
    root_we = 1'b0;
    if (hit) begin
      chk(resp_valid == 1'b1, "R4", resp_valid, 1);
      chk(fill_req == 1'b0, "R4", fill_req, 0);
    end else begin
      chk(resp_valid == 1'b0, "R5", resp_valid, 0);
      chk(fill_req == 1'b1, "R5", fill_req, 1);
      chk(req_ready == 1'b0, "R6", req_ready, 0);
      chk(fill_blk == t, "R5", fill_blk, t);
      chk(fill_pd == cur_pd, "R5", fill_pd, cur_pd);
      chk(fill_root == cur_root, "R5", fill_root, cur_root);
      if (poke) begin
        req_valid = 1'b1;
        req_kind = 2'd0;
        req_addr = a ^ 32'h0000_5550;
        root_we = 1'b1;
        root_in = ~cur_root;
        @(negedge clk);
        req_valid = 1'b0;
        root_we = 1'b0;
      end
      n = 0;
      while (!resp_valid && n < 40) begin
        @(negedge clk);
        n++;
      end
      chk(resp_valid == 1'b1, "R5", resp_valid, 1);
      chk(fills == f0 + 1, "R6", fills - f0, 1);
      m_insert(t);
    end
    chk(resp_allow == ea, tag_of(k), resp_allow, ea);
    chk(fault == !ea, "R7", fault, !ea);
    if (k == 2'd3 && ea && tpd != cur_pd) begin
      cur_pd = tpd;
      m_flush();
    end
    chk(pd_cur == cur_pd, "R8", pd_cur, cur_pd);
    @(negedge clk);
    chk(resp_valid == 1'b0 && fault == 1'b0, "R7", {resp_valid, fault}, 0);
  endtask

  // Find a word in a block range whose gate mark matches g
  function automatic logic [31:0] find_gate(input logic [31:0] base, input bit g);
    for (int i = 0; i < 256; i++) begin
      logic [2:0] e;
      e = tbl(cur_pd, cur_root, base + 32'(i));
      if (e[2] == g) return base + 32'(i);
    end
    return base;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    logic [31:0] ga;
    void'($urandom(32'd1234));
    m_flush();
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_kind = 2'd0;
    req_addr = '0;
    req_target_pd = '0;
    root_we = 1'b0;
    root_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(resp_valid == 1'b0, "R1", resp_valid, 0);
    chk(fault == 1'b0, "R1", fault, 0);
    chk(fill_req == 1'b0, "R1", fill_req, 0);
    chk(pd_cur == 8'd0, "R1", pd_cur, 0);

    // First access must miss (R1), then hits in the same block (R4)
    f0 = fills;
    access(2'd0, 32'h0000_0100, 8'd0, 0, 0, 0);
    chk(fills == f0 + 1, "R1", fills - f0, 1);
    for (int k = 0; k < 4; k++) access(2'(k), 32'h0000_0100 + 32'(k * 3), 8'd0, 0, 0, 0);

    // R9: root write flushes
    write_root(32'hA5A5_0001);
    f0 = fills;
    access(2'd1, 32'h0000_0104, 8'd0, 0, 0, 0);
    chk(fills == f0 + 1, "R9", fills - f0, 1);

    // R10: round-robin eviction
    for (int b = 0; b < 9; b++) access(2'd0, 32'h0001_0000 + 32'(b * 16), 8'd0, 0, 0, 0);
    f0 = fills;
    access(2'd2, 32'h0001_0003, 8'd0, 0, 0, 0);
    chk(fills == f0 + 1, "R10", fills - f0, 1);
    f0 = fills;
    access(2'd0, 32'h0001_0025, 8'd0, 0, 0, 0);
    chk(fills == f0, "R10", fills - f0, 0);

    // R6 and R9: stray request and root write during an outstanding fill
    access(2'd1, 32'h0002_0000, 8'd0, 1, 0, 0);
    f0 = fills;
    access(2'd0, 32'h0002_0040, 8'd0, 0, 0, 0);
    chk(fill_root == 32'hA5A5_0001, "R9", fill_root, 32'hA5A5_0001);

    // R9: root write in the same cycle as a hit
    access(2'd0, 32'h0002_0041, 8'd0, 0, 1, 32'h0BAD_F00D);
    f0 = fills;
    access(2'd0, 32'h0002_0042, 8'd0, 0, 0, 0);
    chk(fills == f0 + 1, "R9", fills - f0, 1);
    chk(fill_root == 32'h0BAD_F00D, "R9", fill_root, 32'h0BAD_F00D);

    // R8: denied transfer keeps domain, allowed transfer switches and flushes
    ga = find_gate(32'h0003_0000, 1'b0);
    access(2'd3, ga, 8'd7, 0, 0, 0);
    chk(pd_cur == 8'd0, "R8", pd_cur, 0);
    ga = find_gate(32'h0003_0000, 1'b1);
    access(2'd3, ga, 8'd5, 0, 0, 0);
    chk(pd_cur == 8'd5, "R8", pd_cur, 5);
    f0 = fills;
    access(2'd0, 32'h0002_0042, 8'd0, 0, 0, 0);
    chk(fills == f0 + 1, "R9", fills - f0, 1);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      logic [31:0] a;
      r = $urandom % 20;
      a = 32'h0000_4000 + 32'(($urandom % 24) * 16) + 32'($urandom % 16);
      if (r == 0) write_root($urandom);
      else access(2'($urandom % 4), a, 8'($urandom % 3), r == 1, r == 2, $urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule